// File: doc/BRIEF.md
# Double-Buffered Serial Receive Path

This block turns a stream of received serial bits into data words and keeps up to two finished words in a small first-in first-out buffer. Software sees the buffer only through one read port: it reads the oldest word and pops it with `rd_en`. The shift register that assembles the word is internal and cannot be reached from the ports. Bit sampling, clock recovery and protocol framing are handled upstream. They deliver one bit per `bit_valid` strobe and mark the end of a frame with `frame_end`.

Two configuration inputs set the word length and the bit order. The transmit path shares the same settings. A word goes into the buffer as soon as its last bit arrives. If the frame ends first, the partial word goes into the buffer as it stands. Words are always right-aligned, and the bits above the word length read as zero. When both entries are full and another word completes, the new word is lost and a sticky overrun flag is raised.

The assembler state machine has two states. `SH_IDLE` means no bits are held, and `SH_ACCUM` means a word is partly assembled. It moves from `SH_IDLE` to `SH_ACCUM` on a bit that does not also finish or flush the word. It returns from `SH_ACCUM` to `SH_IDLE` on a push, which is either a completed word or a frame-end flush. The buffer state machine has three states: `BUF_EMPTY`, `BUF_ONE` and `BUF_FULL`. A push alone moves it one state up (`BUF_EMPTY` to `BUF_ONE`, `BUF_ONE` to `BUF_FULL`). A pop alone moves it one state down. A push and a pop in the same cycle leave the state unchanged. A push in `BUF_FULL` with no pop stays in `BUF_FULL` and sets overrun.

Top module: `srx_path`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 0 and `overrun` is 0.
- R2: With `cfg_msb_first`=0, the first received bit lands in bit 0 of the word and each later bit in the next higher position. The word enters the buffer on the clock edge that samples its last bit, and `rd_valid` is 1 right after that edge.
- R3: With `cfg_msb_first`=1, each received bit shifts in at bit 0 and moves the earlier bits up one place. An L-bit word therefore holds its first bit at position L-1.
- R4: The word length is `cfg_len`+1 for `cfg_len` values 3 to 15, which gives 4 to 16 bits. `cfg_len` values 0 to 2 select 4 bits. Bits of `rd_data` at and above the word length are 0.
- R5: A `frame_end` strobe while k>0 bits are held pushes those k bits, right-aligned in `rd_data`[k-1:0] in the order set by R2/R3. A bit strobed in the same cycle as `frame_end` is counted in the pushed word. The next word starts empty.
- R6: A `frame_end` strobe while no bits are held and no bit is strobed pushes nothing.
- R7: The buffer returns words in arrival order. `rd_data` shows the oldest word while `rd_valid` is 1, a cycle with `rd_en`=1 pops it, and `rd_data` is 0 while `rd_valid` is 0.
- R8: A word that completes while both entries are full and no pop happens in that cycle is dropped. `overrun` becomes 1 and stays 1, and the stored words are unchanged.
- R9: A pop clears `overrun`. A push and a pop in the same cycle while full store the new word without setting `overrun`.
- R10: `rd_en` while `rd_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 4 | Word length minus one, shared with transmit |
| cfg_msb_first | input | 1 | 1: first bit is most significant; 0: least significant |
| bit_valid | input | 1 | A received bit is present on `bit_in` this cycle |
| bit_in | input | 1 | Received bit value |
| frame_end | input | 1 | The current frame ends this cycle |
| rd_en | input | 1 | Read strobe; pops the oldest word |
| rd_data | output | 16 | Oldest buffered word, right-aligned |
| rd_valid | output | 1 | The buffer holds at least one word |
| overrun | output | 1 | A word was dropped because the buffer was full |

## Verification
The hardest situation to reach from the ports is a push and a pop landing on the same clock edge while the buffer is full. It needs two stored words, a third word one bit from completion, and then the final bit and `rd_en` driven in the same cycle. The bench builds this from three four-bit words. It then checks that overrun stays low and that the later two words come out in order. A second corner is a `frame_end` that arrives in the same cycle as a bit. The bench checks that the flushed word includes that bit and that the next word starts from an empty shifter.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic {
        SH_IDLE,
        SH_ACCUM
    } sh_state_t;

    typedef enum logic [1:0] {
        BUF_EMPTY,
        BUF_ONE,
        BUF_FULL
    } buf_state_t;
endpackage

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MIN_LEN = 4,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_msb_first,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              frame_end,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_word
);
    sh_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_nxt, eff_len;
    logic [DATA_W-1:0] word_q, word_base, word_nxt;

    // effective word length, clamped to the minimum
    always_comb begin
        if (cfg_len < LEN_W'(MIN_LEN - 1)) begin
            eff_len = CNT_W'(MIN_LEN);
        end else begin
            eff_len = CNT_W'(cfg_len) + CNT_W'(1);
        end
    end

    // datapath: next word and push decision
    always_comb begin
        cnt_base  = (state_q == SH_IDLE) ? '0 : cnt_q;
        word_base = (state_q == SH_IDLE) ? '0 : word_q;
        cnt_nxt   = cnt_base + CNT_W'(bit_valid);
        word_nxt  = word_base;
        if (bit_valid) begin
            if (cfg_msb_first) begin
                word_nxt = {word_base[DATA_W-2:0], bit_in};
            end else begin
                word_nxt[cnt_base[LEN_W-1:0]] = bit_in;
            end
        end
        push_valid = (bit_valid && (cnt_nxt == eff_len))
                   || (frame_end && (cnt_nxt != '0));
        push_word  = word_nxt;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (bit_valid && !push_valid) state_d = SH_ACCUM;
            SH_ACCUM: if (push_valid)               state_d = SH_IDLE;
            default:  state_d = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // accumulator registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (push_valid) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (bit_valid) begin
            cnt_q  <= cnt_nxt;
            word_q <= word_nxt;
        end
    end
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer
    import srx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_word,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              overrun
);
    buf_state_t        state_q, state_d;
    logic [DATA_W-1:0] head_q, head_d, tail_q, tail_d;
    logic              ovr_q, ovr_d;
    logic              pop;

    assign pop = rd_en && (state_q != BUF_EMPTY);

    // next-state and entry update
    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        tail_d  = tail_q;
        ovr_d   = pop ? 1'b0 : ovr_q;
        unique case (state_q)
            BUF_EMPTY: begin
                if (push_valid) begin
                    head_d  = push_word;
                    state_d = BUF_ONE;
                end
            end
            BUF_ONE: begin
                if (push_valid && pop) begin
                    head_d = push_word;
                end else if (push_valid) begin
                    tail_d  = push_word;
                    state_d = BUF_FULL;
                end else if (pop) begin
                    state_d = BUF_EMPTY;
                end
            end
            BUF_FULL: begin
                if (pop) begin
                    head_d = tail_q;
                    if (push_valid) begin
                        tail_d = push_word;
                    end else begin
                        state_d = BUF_ONE;
                    end
                end else if (push_valid) begin
                    ovr_d = 1'b1;
                end
            end
            default: state_d = BUF_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
            ovr_q   <= ovr_d;
        end
    end

    // outputs
    always_comb begin
        rd_valid = (state_q != BUF_EMPTY);
        rd_data  = rd_valid ? head_q : '0;
        overrun  = ovr_q;
    end
endmodule

// File: rtl/srx_path.sv
module srx_path #(
    parameter int DATA_W = 16,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_msb_first,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              frame_end,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              overrun
);
    logic              push_valid;
    logic [DATA_W-1:0] push_word;

    srx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len       (cfg_len),
        .cfg_msb_first (cfg_msb_first),
        .bit_valid     (bit_valid),
        .bit_in        (bit_in),
        .frame_end     (frame_end),
        .push_valid    (push_valid),
        .push_word     (push_word)
    );

    srx_buffer #(.DATA_W(DATA_W)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_word  (push_word),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .overrun    (overrun)
    );
endmodule

// File: rtl/srx_path_chk.sv
module srx_path_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_valid,
    input logic              frame_end,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              overrun
);
    // R7: an empty buffer reads as zero
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R7: with no read, the head word is held
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    // R6: no strobe, no new entry
    p_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !bit_valid && !frame_end) |=> !rd_valid);

    // R8: overrun is sticky until a pop
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_en) |=> overrun);

    // R8: overrun implies stored data
    p_overrun_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rd_valid);

    // R9: a pop clears overrun
    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid) |=> !overrun);

    // R10: read of an empty buffer changes nothing
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_en && !bit_valid && !frame_end) |=> (!rd_valid && !overrun));
endmodule

bind srx_path srx_path_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .frame_end (frame_end),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .overrun   (overrun)
);

// File: tb/test_srx_path.sv
module test_srx_path;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        msb;
        logic [3:0]  len;
        logic [4:0]  nbits;
        logic [15:0] bits;
        logic        fe;
        logic [15:0] exp;
    } vec_t;

    // bits[i] is the i-th bit sent
    localparam vec_t VECS [9] = '{
        '{1'b0, 4'd7,  5'd8,  16'h00A5, 1'b0, 16'h00A5},
        '{1'b1, 4'd7,  5'd8,  16'h0001, 1'b0, 16'h0080},
        '{1'b0, 4'd15, 5'd16, 16'hBEEF, 1'b0, 16'hBEEF},
        '{1'b1, 4'd15, 5'd16, 16'h1234, 1'b0, 16'h2C48},
        '{1'b0, 4'd3,  5'd4,  16'h00FF, 1'b0, 16'h000F},
        '{1'b0, 4'd0,  5'd4,  16'h000A, 1'b0, 16'h000A},
        '{1'b0, 4'd15, 5'd5,  16'h0013, 1'b1, 16'h0013},
        '{1'b1, 4'd15, 5'd3,  16'h0001, 1'b1, 16'h0004},
        '{1'b1, 4'd11, 5'd12, 16'h0003, 1'b0, 16'h0C00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_len = 4'd7;
    logic        cfg_msb_first = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        frame_end = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        overrun;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    srx_path i_srx_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len       (cfg_len),
        .cfg_msb_first (cfg_msb_first),
        .bit_valid     (bit_valid),
        .bit_in        (bit_in),
        .frame_end     (frame_end),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .overrun       (overrun)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic fe);
        bit_valid = 1'b1;
        bit_in    = b;
        frame_end = fe;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] b, input int n);
        for (int i = 0; i < n; i++) send_bit(b[i], 1'b0);
    endtask

    task automatic pulse_fe();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        check("R1", "rd_valid in reset", rd_valid, 0);
        check("R1", "rd_data in reset", rd_data, 0);
        check("R1", "overrun in reset", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_valid after reset", rd_valid, 0);

        // vector table
        foreach (VECS[v]) begin
            cfg_msb_first = VECS[v].msb;
            cfg_len       = VECS[v].len;
            @(negedge clk);
            send_bits(VECS[v].bits, int'(VECS[v].nbits));
            if (VECS[v].fe) pulse_fe();
            tag = VECS[v].fe ? "R5" : (VECS[v].len < 4'd3 ? "R4"
                  : (VECS[v].msb ? "R3" : "R2"));
            check(tag, $sformatf("vector %0d rd_valid", v), rd_valid, 1);
            check(tag, $sformatf("vector %0d rd_data", v), rd_data, VECS[v].exp);
            do_read();
            check("R7", $sformatf("vector %0d drained", v), rd_valid, 0);
        end

        // R6: frame end with nothing held
        cfg_msb_first = 1'b0;
        cfg_len       = 4'd15;
        pulse_fe();
        @(negedge clk);
        check("R6", "frame end on idle shifter", rd_valid, 0);

        // R5: frame end with the last bit in the same cycle, then fresh word
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);
        check("R5", "same-cycle flush valid", rd_valid, 1);
        check("R5", "same-cycle flush data", rd_data, 16'h0007);
        do_read();
        cfg_len = 4'd3;
        send_bits(16'h000A, 4);
        check("R5", "word after flush starts empty", rd_data, 16'h000A);
        do_read();
        pulse_fe();
        check("R6", "frame end after full word", rd_valid, 0);

        // R8/R9/R10: overrun
        send_bits(16'h0001, 4);
        send_bits(16'h0002, 4);
        check("R8", "overrun before third word", overrun, 0);
        send_bits(16'h0003, 4);
        check("R8", "overrun set", overrun, 1);
        check("R8", "head kept after drop", rd_data, 16'h0001);
        do_read();
        check("R9", "overrun cleared by pop", overrun, 0);
        check("R8", "second word kept", rd_data, 16'h0002);
        do_read();
        check("R7", "empty after two pops", rd_valid, 0);
        do_read();
        check("R10", "empty read valid", rd_valid, 0);
        check("R10", "empty read data", rd_data, 0);
        check("R10", "empty read overrun", overrun, 0);
        send_bits(16'h0009, 4);
        check("R10", "word after empty read", rd_data, 16'h0009);
        do_read();

        // R9: push and pop together while full
        send_bits(16'h0004, 4);
        send_bits(16'h0005, 4);
        send_bits(16'h0006, 3);
        rd_en = 1'b1;
        send_bit(1'b0, 1'b0);
        rd_en = 1'b0;
        check("R9", "no overrun on push with pop", overrun, 0);
        check("R9", "head after push with pop", rd_data, 16'h0005);
        do_read();
        check("R9", "new word stored", rd_data, 16'h0006);
        do_read();
        check("R7", "empty at end", rd_valid, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule